// File: doc/BRIEF.md
# Circular Done-Queue Pointer Manager

This block keeps the bookkeeping for a ring of completion descriptors that a DMA engine writes into host memory. Software programs a 32-bit ring origin in two 16-bit halves, a last-entry index relative to that origin, and a consumer index that it moves forward as it retires entries. The DMA engine asks for one slot at a time. The block answers with the byte address of the slot, which is the origin plus four times the producer index. It then moves the producer index forward and wraps it to zero past the last entry.

Software learns of new completions through a sticky status flag. The flag can be set on every slot handed out, or only once per group of 2, 4, 8, 16, 32, 64 or 128 slots. An idle timer raises the flag early when a partial group has waited too long. Requests are held off while DMA is disabled, and while handing out a slot would make the producer index catch up with the consumer index.

Top module: `dq_ptr_mgr`

## Requirements
- R1: The ring origin is written as a low half at register 0 and a high half at register 1, and each half reads back unchanged.
- R2: Each granted slot is presented on dma_addr together with dma_ack, and its value is origin + 4 × producer index, where the producer index is the value it had before the grant.
- R3: Each grant advances the producer index by one, and software can read it at register 4.
- R4: When the producer index is at or beyond the last-entry index (register 2), a grant returns it to 0.
- R5: While the enable bit (register 5 bit 0) is clear, no request is acknowledged and the producer index does not move.
- R6: When the advanced producer index would equal the consumer index (register 3), q_full is high and requests are held off. Service resumes once software moves the consumer index.
- R7: The 3-bit field at register 5 bits 3:1 with value t sets the status flag on every 2^t-th grant. A value of 0 sets it on every grant, and the grant counter clears whenever the flag is raised.
- R8: The status flag (register 7 bit 0, also on status_flag) stays set until software writes 1 to that bit. A set event in the same cycle as the clear wins.
- R9: With a nonzero idle limit N at register 6 and a nonzero grant count, the flag is raised N cycles after the last grant if no further grant arrives. An idle limit of 0 disables this.
- R10: dma_ack is a single-cycle pulse that rises on the clock edge after a grantable request, so an engine that holds dma_req gets at most one slot every two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Register write strobe |
| host_addr | input | 3 | Register select |
| host_wdata | input | 16 | Register write data |
| host_rdata | output | 16 | Registered read data for host_addr, one cycle later |
| dma_req | input | 1 | Engine asks for a completion slot |
| dma_ack | output | 1 | Slot granted, dma_addr valid |
| dma_addr | output | 32 | Byte address of the granted slot |
| q_full | output | 1 | Next grant would reach the consumer index |
| status_flag | output | 1 | Sticky completion flag |

## Verification
The assertions check on every cycle that acknowledges are single pulses and only follow an enabled request. They also check that the producer index moves only on a grant, that it returns to zero past the last entry, and that the flag stays set until it is cleared. The bench scenarios cover what needs a history of stimulus. These are the slot addresses across a wrap, the hold-off when the ring is full and the recovery after the consumer index moves, the exact grant count for each threshold setting, the cycle on which the idle timer fires, and a set that collides with a clear.

// File: rtl/dq_pkg.sv
package dq_pkg;
  typedef enum logic [2:0] {
    RA_ORG_LO = 3'd0,
    RA_ORG_HI = 3'd1,
    RA_LAST   = 3'd2,
    RA_CONS   = 3'd3,
    RA_PROD   = 3'd4,
    RA_CTRL   = 3'd5,
    RA_IDLE   = 3'd6,
    RA_STAT   = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/dq_regs.sv
module dq_regs
  import dq_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int PTR_W  = 16,
  parameter int THR_W  = 3,
  parameter int TMR_W  = 16,
  localparam int ADDR_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic [2:0]        host_addr,
  input  logic [HALF_W-1:0] host_wdata,
  input  logic [PTR_W-1:0]  prod_idx,
  input  logic              flag,
  input  logic              full,
  output logic [ADDR_W-1:0] origin,
  output logic [PTR_W-1:0]  last_idx,
  output logic [PTR_W-1:0]  cons_idx,
  output logic              dma_en,
  output logic [THR_W-1:0]  thr,
  output logic [TMR_W-1:0]  idle_lim,
  output logic              flag_clr,
  output logic [HALF_W-1:0] host_rdata
);
  logic [HALF_W-1:0] org_lo, org_hi;

  assign origin   = {org_hi, org_lo};
  assign flag_clr = host_wr && (host_addr == RA_STAT) && host_wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      org_lo   <= '0;
      org_hi   <= '0;
      last_idx <= '0;
      cons_idx <= '0;
      dma_en   <= 1'b0;
      thr      <= '0;
      idle_lim <= '0;
    end else if (host_wr) begin
      case (host_addr)
        RA_ORG_LO: org_lo   <= host_wdata;
        RA_ORG_HI: org_hi   <= host_wdata;
        RA_LAST:   last_idx <= host_wdata[PTR_W-1:0];
        RA_CONS:   cons_idx <= host_wdata[PTR_W-1:0];
        RA_CTRL: begin
          dma_en <= host_wdata[0];
          thr    <= host_wdata[THR_W:1];
        end
        RA_IDLE:   idle_lim <= host_wdata[TMR_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) host_rdata <= '0;
    else begin
      case (host_addr)
        RA_ORG_LO: host_rdata <= org_lo;
        RA_ORG_HI: host_rdata <= org_hi;
        RA_LAST:   host_rdata <= HALF_W'(last_idx);
        RA_CONS:   host_rdata <= HALF_W'(cons_idx);
        RA_PROD:   host_rdata <= HALF_W'(prod_idx);
        RA_CTRL:   host_rdata <= HALF_W'({thr, dma_en});
        RA_IDLE:   host_rdata <= HALF_W'(idle_lim);
        default:   host_rdata <= HALF_W'({full, flag});
      endcase
    end
  end
endmodule

// File: rtl/dq_wptr.sv
module dq_wptr #(
  parameter int PTR_W  = 16,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              en,
  input  logic [ADDR_W-1:0] origin,
  input  logic [PTR_W-1:0]  last_idx,
  input  logic [PTR_W-1:0]  cons_idx,
  output logic              grant,
  output logic              ack,
  output logic [ADDR_W-1:0] slot_addr,
  output logic [PTR_W-1:0]  prod_idx,
  output logic              full
);
  logic [PTR_W-1:0] prod_next;

  assign prod_next = (prod_idx >= last_idx) ? '0 : prod_idx + 1'b1;
  assign full      = (prod_next == cons_idx);
  assign grant     = req && en && !full && !ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      prod_idx  <= '0;
      ack       <= 1'b0;
      slot_addr <= '0;
    end else begin
      ack <= grant;
      if (grant) begin
        slot_addr <= origin + ADDR_W'({prod_idx, 2'b00});
        prod_idx  <= prod_next;
      end
    end
  end

  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack); // R10
  AST_ACK_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    $rose(ack) |-> $past(en && req)); // R5
  AST_PROD_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !grant |=> $stable(prod_idx)); // R3
  AST_PROD_WRAP: assert property (@(posedge clk) disable iff (rst)
    (grant && (prod_idx >= last_idx)) |=> (prod_idx == '0)); // R4
endmodule

// File: rtl/dq_status.sv
module dq_status #(
  parameter int THR_W = 3,
  parameter int TMR_W = 16,
  localparam int CNT_W = 2 ** THR_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             grant,
  input  logic [THR_W-1:0] thr,
  input  logic [TMR_W-1:0] idle_lim,
  input  logic             clr,
  output logic             flag
);
  logic [CNT_W-1:0] cnt, cnt_inc;
  logic [CNT_W:0]   group;
  logic [TMR_W-1:0] tmr, tmr_inc;
  logic             wr_evt, idle_evt, evt;

  assign cnt_inc  = cnt + 1'b1;
  assign tmr_inc  = tmr + 1'b1;
  assign group    = (CNT_W+1)'(1) << thr;
  assign wr_evt   = grant && ({1'b0, cnt_inc} >= group);
  assign idle_evt = !grant && (cnt != '0) && (idle_lim != '0) && (tmr_inc >= idle_lim);
  assign evt      = wr_evt || idle_evt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tmr  <= '0;
      flag <= 1'b0;
    end else begin
      if (grant)         cnt <= wr_evt ? '0 : cnt_inc;
      else if (idle_evt) cnt <= '0;
      if (grant || idle_evt || cnt == '0) tmr <= '0;
      else                                tmr <= tmr_inc;
      if (evt)      flag <= 1'b1;
      else if (clr) flag <= 1'b0;
    end
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr) |=> flag); // R8
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (grant && thr == '0) |=> flag); // R7
endmodule

// File: rtl/dq_ptr_mgr.sv
module dq_ptr_mgr #(
  parameter int HALF_W = 16,
  parameter int PTR_W  = 16,
  parameter int THR_W  = 3,
  parameter int TMR_W  = 16,
  localparam int ADDR_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic [2:0]        host_addr,
  input  logic [HALF_W-1:0] host_wdata,
  output logic [HALF_W-1:0] host_rdata,
  input  logic              dma_req,
  output logic              dma_ack,
  output logic [ADDR_W-1:0] dma_addr,
  output logic              q_full,
  output logic              status_flag
);
  logic [ADDR_W-1:0] origin;
  logic [PTR_W-1:0]  last_idx, cons_idx, prod_idx;
  logic              dma_en, flag_clr, grant;
  logic [THR_W-1:0]  thr;
  logic [TMR_W-1:0]  idle_lim;

  dq_regs #(.HALF_W(HALF_W), .PTR_W(PTR_W), .THR_W(THR_W), .TMR_W(TMR_W)) u_regs (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .prod_idx(prod_idx), .flag(status_flag),
    .full(q_full), .origin(origin), .last_idx(last_idx), .cons_idx(cons_idx),
    .dma_en(dma_en), .thr(thr), .idle_lim(idle_lim), .flag_clr(flag_clr),
    .host_rdata(host_rdata)
  );

  dq_wptr #(.PTR_W(PTR_W), .ADDR_W(ADDR_W)) u_wptr (
    .clk(clk), .rst(rst), .req(dma_req), .en(dma_en), .origin(origin),
    .last_idx(last_idx), .cons_idx(cons_idx), .grant(grant), .ack(dma_ack),
    .slot_addr(dma_addr), .prod_idx(prod_idx), .full(q_full)
  );

  dq_status #(.THR_W(THR_W), .TMR_W(TMR_W)) u_status (
    .clk(clk), .rst(rst), .grant(grant), .thr(thr), .idle_lim(idle_lim),
    .clr(flag_clr), .flag(status_flag)
  );

  AST_NO_ACK_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
    (q_full && !host_wr) |=> !dma_ack); // R6
endmodule

// File: tb/dq_ptr_mgr_tb.sv
`timescale 1ns/1ps
module dq_ptr_mgr_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr = 1'b0;
  logic [2:0]  host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        dma_req = 1'b0;
  logic        dma_ack;
  logic [31:0] dma_addr;
  logic        q_full;
  logic        status_flag;

  int n_chk = 0;
  int n_err = 0;
  logic [31:0] org_m = '0;
  logic [15:0] last_m = '0;
  logic [15:0] prod_m = '0;

  always #4 clk = ~clk;

  dq_ptr_mgr u_dut (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .dma_req(dma_req),
    .dma_ack(dma_ack), .dma_addr(dma_addr), .q_full(q_full),
    .status_flag(status_flag)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic host_write(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic host_read(logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    host_addr = a;
    @(negedge clk);
    d = host_rdata;
  endtask

  task automatic adv_model();
    prod_m = (prod_m >= last_m) ? 16'd0 : prod_m + 16'd1;
  endtask

  task automatic dma_write(string tag);
    int n = 0;
    logic [31:0] exp;
    exp = org_m + {14'd0, prod_m, 2'b00};
    @(negedge clk);
    dma_req = 1'b1;
    do begin
      @(negedge clk);
      n++;
    end while (!dma_ack && n < 20);
    dma_req = 1'b0;
    check({tag, " ack"}, {31'd0, dma_ack}, 32'd1);
    check("R2 slot address", dma_addr, exp);
    adv_model();
  endtask

  task automatic dma_blocked(string tag);
    int seen = 0;
    @(negedge clk);
    dma_req = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (dma_ack) seen++;
    end
    dma_req = 1'b0;
    check({tag, " no ack"}, seen, 0);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    check("R10 ack idle at reset", {31'd0, dma_ack}, 32'd0);
    check("R8 flag clear at reset", {31'd0, status_flag}, 32'd0);
    host_read(3'd4, d);
    check("R3 producer index at reset", {16'd0, d}, 32'd0);
  endtask

  task automatic t_origin();
    logic [15:0] d;
    host_write(3'd0, 16'h1000);
    host_write(3'd1, 16'h8000);
    org_m = 32'h8000_1000;
    host_read(3'd0, d);
    check("R1 origin low half", {16'd0, d}, 32'h1000);
    host_read(3'd1, d);
    check("R1 origin high half", {16'd0, d}, 32'h8000);
  endtask

  task automatic t_fill_wrap();
    logic [15:0] d;
    host_write(3'd2, 16'd3); last_m = 16'd3;
    host_write(3'd3, 16'd0);
    host_write(3'd5, 16'h0001);
    for (int i = 0; i < 3; i++) dma_write("R3 fill");
    host_read(3'd4, d);
    check("R3 producer index after 3", {16'd0, d}, 32'd3);
    check("R6 full flag", {31'd0, q_full}, 32'd1);
    dma_blocked("R6 held off when full");
    host_write(3'd3, 16'd2);
    check("R6 full released", {31'd0, q_full}, 32'd0);
    dma_write("R6 resumed");
    host_read(3'd4, d);
    check("R4 wrap to zero", {16'd0, d}, 32'd0);
    dma_write("R4 after wrap");
    dma_blocked("R6 held off again");
  endtask

  task automatic t_flag_clear();
    check("R7 flag on every write", {31'd0, status_flag}, 32'd1);
    host_write(3'd7, 16'h0001);
    check("R8 write-1 clears flag", {31'd0, status_flag}, 32'd0);
  endtask

  task automatic t_disable();
    logic [15:0] d;
    host_write(3'd2, 16'd255); last_m = 16'd255;
    host_write(3'd3, 16'h0080);
    host_write(3'd5, 16'h0000);
    dma_blocked("R5 disabled");
    host_read(3'd4, d);
    check("R5 index frozen while disabled", {16'd0, d}, {16'd0, prod_m});
    check("R5 flag untouched while disabled", {31'd0, status_flag}, 32'd0);
  endtask

  task automatic t_threshold();
    host_write(3'd5, 16'h0005);
    for (int i = 0; i < 3; i++) begin
      dma_write("R7 group of 4");
      check("R7 flag low before 4th", {31'd0, status_flag}, 32'd0);
    end
    dma_write("R7 group of 4");
    check("R7 flag on 4th write", {31'd0, status_flag}, 32'd1);
    host_write(3'd7, 16'h0001);
    host_write(3'd5, 16'h0003);
    dma_write("R7 group of 2");
    check("R7 flag low after 1 of 2", {31'd0, status_flag}, 32'd0);
    dma_write("R7 group of 2");
    check("R7 flag on 2nd of 2", {31'd0, status_flag}, 32'd1);
  endtask

  task automatic t_idle();
    host_write(3'd7, 16'h0001);
    host_write(3'd5, 16'h0007);
    host_write(3'd6, 16'd10);
    dma_write("R9 partial group");
    dma_write("R9 partial group");
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk);
      if (k == 9)  check("R9 flag low before limit", {31'd0, status_flag}, 32'd0);
      if (k == 10) check("R9 flag at idle limit", {31'd0, status_flag}, 32'd1);
    end
    host_write(3'd7, 16'h0001);
    host_write(3'd6, 16'd0);
    dma_write("R9 disabled timer");
    repeat (30) @(negedge clk);
    check("R9 zero limit never fires", {31'd0, status_flag}, 32'd0);
  endtask

  task automatic t_collide();
    logic [31:0] exp;
    host_write(3'd5, 16'h0001);
    dma_write("R8 set flag");
    check("R8 flag set", {31'd0, status_flag}, 32'd1);
    exp = org_m + {14'd0, prod_m, 2'b00};
    @(negedge clk);
    dma_req = 1'b1; host_wr = 1'b1; host_addr = 3'd7; host_wdata = 16'h0001;
    @(negedge clk);
    dma_req = 1'b0; host_wr = 1'b0;
    check("R8 collide ack", {31'd0, dma_ack}, 32'd1);
    check("R2 collide address", dma_addr, exp);
    adv_model();
    check("R8 set wins over clear", {31'd0, status_flag}, 32'd1);
    host_write(3'd7, 16'h0001);
    check("R8 plain clear", {31'd0, status_flag}, 32'd0);
  endtask

  task automatic t_pulse();
    logic [15:0] d;
    int acks = 0;
    int back2back = 0;
    logic prev = 1'b0;
    @(negedge clk);
    dma_req = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (dma_ack && prev) back2back++;
      if (dma_ack) begin
        acks++;
        adv_model();
      end
      prev = dma_ack;
    end
    dma_req = 1'b0;
    check("R10 no back-to-back ack", back2back, 0);
    check("R10 one ack per two cycles", acks, 3);
    host_read(3'd4, d);
    check("R3 final producer index", {16'd0, d}, {16'd0, prod_m});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_origin();
    t_fill_wrap();
    t_flag_clear();
    t_disable();
    t_threshold();
    t_idle();
    t_collide();
    t_pulse();
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule